// File: doc/BRIEF.md
# Unique Monotonic Timestamp Generator

This block is the per-core end of a shared time-of-day service. A counter of time units runs freely inside the core. A read returns a single word: the current time count in the upper field and a fixed core number in the lower field. Every core that shares the time base has a different core number. Two cores that read in the same cycle therefore still get different words, and no central arbiter is needed to keep the values unique.

A core never returns the same time field twice. Once a read has captured a time value, the next read on that core waits until the counter has moved past it. The counter moves only on an internal tick that comes once every `TICK_DIV` core cycles. An immediate second read therefore stalls for up to one tick period.

A two-bit slew input trims the step added on each tick. The step can be one unit larger or one unit smaller than the nominal step. This lets outside logic pull the count toward a reference by changing its rate. The count is never written directly and never goes backward.

Top module: `ts_unique_gen`

## Requirements
- R1: During and after reset `rd_valid_o` is 0 and the time count is 0. A read issued before the first tick returns a time field of 0.
- R2: Each returned word is `{time, CORE_ID}`. The core number sits in the low `ID_W` bits (default `8'h5C`) and the time field sits in bits `[TIME_W+ID_W-1:ID_W]`.
- R3: Successive words returned by one core strictly increase, and no word is returned twice.
- R4: The time count changes only on a tick, which occurs once every `TICK_DIV` cycles (default 4) counted from reset release. On each tick the count grows by the current step.
- R5: Slew encoding sampled at the tick: `2'b01` uses step BASE_INC+1, `2'b10` uses BASE_INC-1, and `2'b00` and `2'b11` use BASE_INC (default 1).
- R6: The step is clamped to at least 1. With the default BASE_INC of 1, the slow setting still advances the count by 1 per tick.
- R7: A read whose time field would equal the last returned time field is stalled, with `rd_valid_o` held low, until the count has advanced. A read made after the count has advanced is not stalled.
- R8: Handshake: `rd_req_i` is held high until the word appears. `rd_valid_o` and `rd_stamp_o` appear one cycle after the request is accepted, and the word carries the count present in the accepting cycle.
- R9: The first read after reset is never stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slew_i | input | 2 | Step trim: 01 faster, 10 slower, 00/11 nominal |
| rd_req_i | input | 1 | Read request, held until `rd_valid_o` |
| rd_valid_o | output | 1 | Returned word is valid this cycle |
| rd_stamp_o | output | TIME_W+ID_W | Returned word `{time, CORE_ID}` |

## Verification
The hardest case to reach is a read that arrives while the time field still equals the last returned one. This happens only when a second request follows a granted one inside the same tick period. The bench drives back-to-back reads so that each one lands inside the tick window of the read before it. It runs these under each slew setting and measures how many cycles each read stalls. The distance between the two returned time fields must then equal exactly one step, which also exposes the clamp on the slow setting.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [1:0] {
    SLEW_NOM  = 2'b00,
    SLEW_FAST = 2'b01,
    SLEW_SLOW = 2'b10,
    SLEW_HOLD = 2'b11
  } slew_e;

  // Step applied on one tick: nominal trimmed by +/-1, never below one.
  function automatic int unsigned calc_step(input int unsigned base, input logic [1:0] slew);
    int signed s;
    s = int'(base);
    case (slew_e'(slew))
      SLEW_FAST: s = s + 1;
      SLEW_SLOW: s = s - 1;
      default:   s = s;
    endcase
    if (s < 1) s = 1;
    return unsigned'(s);
  endfunction

endpackage

// File: rtl/ts_tick_gen.sv
module ts_tick_gen #(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  generate
    if (TICK_DIV <= 1) begin : g_every
      assign tick_o = 1'b1;
    end else begin : g_div
      localparam int unsigned CW = $clog2(TICK_DIV);
      localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)             cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
      end
      assign tick_o = (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/ts_time_count.sv
module ts_time_count
  import ts_pkg::*;
#(
  parameter int unsigned TIME_W   = 32,
  parameter int unsigned BASE_INC = 1,
  localparam int unsigned STEP_W  = $clog2(BASE_INC + 2) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [1:0]        slew_i,
  output logic [STEP_W-1:0] step_o,
  output logic [TIME_W-1:0] time_o
);
  logic [TIME_W-1:0] time_q;

  assign step_o = STEP_W'(calc_step(BASE_INC, slew_i));

  always_ff @(posedge clk) begin
    if (!rst_n)      time_q <= '0;
    else if (tick_i) time_q <= time_q + TIME_W'(step_o);
  end

  assign time_o = time_q;
endmodule

// File: rtl/ts_read_gate.sv
module ts_read_gate #(
  parameter int unsigned        TIME_W  = 32,
  parameter int unsigned        ID_W    = 8,
  parameter logic [ID_W-1:0]    CORE_ID = 8'h5C,
  localparam int unsigned       OUT_W   = TIME_W + ID_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              grant_o,
  output logic              stall_o,
  output logic              last_vld_o,
  output logic [TIME_W-1:0] last_time_o,
  output logic              valid_o,
  output logic [OUT_W-1:0]  stamp_o
);
  logic              last_vld_q;
  logic [TIME_W-1:0] last_time_q;
  logic              valid_q;
  logic [OUT_W-1:0]  stamp_q;
  logic              same_tick;

  assign same_tick = last_vld_q && (time_i == last_time_q);
  assign stall_o   = req_i && same_tick;
  assign grant_o   = req_i && !same_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_vld_q  <= 1'b0;
      last_time_q <= '0;
      valid_q     <= 1'b0;
      stamp_q     <= '0;
    end else begin
      valid_q <= grant_o;
      if (grant_o) begin
        last_vld_q  <= 1'b1;
        last_time_q <= time_i;
        stamp_q     <= {time_i, CORE_ID};
      end
    end
  end

  assign last_vld_o  = last_vld_q;
  assign last_time_o = last_time_q;
  assign valid_o     = valid_q;
  assign stamp_o     = stamp_q;
endmodule

// File: rtl/ts_unique_gen.sv
module ts_unique_gen #(
  parameter int unsigned     TIME_W   = 32,
  parameter int unsigned     ID_W     = 8,
  parameter logic [ID_W-1:0] CORE_ID  = 8'h5C,
  parameter int unsigned     TICK_DIV = 4,
  parameter int unsigned     BASE_INC = 1,
  localparam int unsigned    OUT_W    = TIME_W + ID_W,
  localparam int unsigned    STEP_W   = $clog2(BASE_INC + 2) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       slew_i,
  input  logic             rd_req_i,
  output logic             rd_valid_o,
  output logic [OUT_W-1:0] rd_stamp_o
);
  logic              tick_w;
  logic [STEP_W-1:0] step_w;
  logic [TIME_W-1:0] time_w;
  logic              grant_w;
  logic              stall_w;
  logic              last_vld_w;
  logic [TIME_W-1:0] last_time_w;

  ts_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick_w)
  );

  ts_time_count #(.TIME_W(TIME_W), .BASE_INC(BASE_INC)) u_count (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick_w),
    .slew_i (slew_i),
    .step_o (step_w),
    .time_o (time_w)
  );

  ts_read_gate #(.TIME_W(TIME_W), .ID_W(ID_W), .CORE_ID(CORE_ID)) u_gate (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_i       (rd_req_i),
    .time_i      (time_w),
    .grant_o     (grant_w),
    .stall_o     (stall_w),
    .last_vld_o  (last_vld_w),
    .last_time_o (last_time_w),
    .valid_o     (rd_valid_o),
    .stamp_o     (rd_stamp_o)
  );
endmodule

// File: rtl/ts_unique_gen_chk.sv
module ts_unique_gen_chk #(
  parameter int unsigned     TIME_W   = 32,
  parameter int unsigned     ID_W     = 8,
  parameter logic [ID_W-1:0] CORE_ID  = 8'h5C,
  parameter int unsigned     BASE_INC = 1,
  localparam int unsigned    OUT_W    = TIME_W + ID_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [TIME_W-1:0] time_cnt,
  input logic              grant,
  input logic              stall,
  input logic              last_vld,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [OUT_W-1:0]  rd_stamp
);
  logic [OUT_W-1:0] prev_q;
  logic             seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else if (rd_valid) begin
      prev_q <= rd_stamp;
      seen_q <= 1'b1;
    end
  end

  p_low_id_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_stamp[ID_W-1:0] == CORE_ID);

  p_mono_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && seen_q) |-> rd_stamp > prev_q);

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_cnt));

  p_tick_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (time_cnt != $past(time_cnt)) &&
             ((time_cnt - $past(time_cnt)) <= TIME_W'(BASE_INC + 1)));

  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> !rd_valid);

  p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> rd_valid && rd_stamp[OUT_W-1:ID_W] == $past(time_cnt));

  p_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !last_vld) |=> rd_valid);
endmodule

bind ts_unique_gen ts_unique_gen_chk #(
  .TIME_W(TIME_W), .ID_W(ID_W), .CORE_ID(CORE_ID), .BASE_INC(BASE_INC)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick_w),
  .time_cnt (time_w),
  .grant    (grant_w),
  .stall    (stall_w),
  .last_vld (last_vld_w),
  .rd_req   (rd_req_i),
  .rd_valid (rd_valid_o),
  .rd_stamp (rd_stamp_o)
);

// File: tb/ts_unique_gen_tb_top.sv
module ts_unique_gen_tb_top;
  localparam int unsigned TIME_W   = 32;
  localparam int unsigned ID_W     = 8;
  localparam logic [7:0]  CORE_ID  = 8'h5C;
  localparam int unsigned TICK_DIV = 4;
  localparam int unsigned BASE_INC = 1;
  localparam int unsigned W        = TIME_W + ID_W;

  typedef struct {
    logic [W-1:0] val;
    string        tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   slew = 2'b00;
  logic         rd_req = 1'b0;
  logic         rd_valid;
  logic [W-1:0] rd_stamp;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  exp_t sb_q[$];

  // Bench time model restated from R4-R6.
  int unsigned  m_div = 0;
  logic [TIME_W-1:0] m_time = '0;
  bit           m_last_vld = 0;
  logic [TIME_W-1:0] m_last = '0;

  always #2 clk = ~clk;

  ts_unique_gen #(
    .TIME_W(TIME_W), .ID_W(ID_W), .CORE_ID(CORE_ID),
    .TICK_DIV(TICK_DIV), .BASE_INC(BASE_INC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .slew_i(slew),
    .rd_req_i(rd_req), .rd_valid_o(rd_valid), .rd_stamp_o(rd_stamp)
  );

  function automatic int unsigned exp_step(input logic [1:0] s);
    int unsigned v;
    if (s == 2'b01)      v = BASE_INC + 1;
    else if (s == 2'b10) v = (BASE_INC > 1) ? BASE_INC - 1 : 1;
    else                 v = BASE_INC;
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_div  <= 0;
      m_time <= '0;
    end else if (m_div == TICK_DIV - 1) begin
      m_div  <= 0;
      m_time <= m_time + TIME_W'(exp_step(slew));
    end else begin
      m_div <= m_div + 1;
    end
  end

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Monitor: pops expected words as the design returns them.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (sb_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R8: unexpected valid, stamp %h expected no valid", rd_stamp);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, rd_stamp, e.val);
        check("R2", W'(rd_stamp[ID_W-1:0]), W'(CORE_ID));
      end
    end
  end

  // Driver: one read, starting and ending on a falling edge.
  task automatic do_read(input string tag, output logic [W-1:0] got, output int waited);
    exp_t e;
    rd_req = 1'b1;
    waited = 0;
    while (m_last_vld && (m_time == m_last)) begin
      @(negedge clk);
      waited++;
    end
    e.val = {m_time, CORE_ID};
    e.tag = tag;
    sb_q.push_back(e);
    m_last = m_time;
    m_last_vld = 1;
    @(negedge clk);
    rd_req = 1'b0;
    got = rd_stamp;
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] a, b;
    int wa, wb;
    repeat (5) @(negedge clk);
    check("R1", W'(rd_valid), W'(0));
    rst_n = 1'b1;

    // R9 / R1: first read is immediate and carries time 0
    do_read("R9", a, wa);
    check("R9", W'(wa), W'(0));
    check("R1", a, {32'd0, CORE_ID});

    // R7 / R4: back-to-back read stalls for the tick, then steps by nominal
    do_read("R7", b, wb);
    check("R7", W'(wb > 0), W'(1));
    check("R4", W'(b[W-1:ID_W] - a[W-1:ID_W]), W'(exp_step(2'b00)));

    // R5: fast slew
    slew = 2'b01;
    do_read("R5", a, wa);
    do_read("R5", b, wb);
    check("R5", W'(b[W-1:ID_W] - a[W-1:ID_W]), W'(BASE_INC + 1));

    // R6: slow slew clamps at one
    slew = 2'b10;
    do_read("R6", a, wa);
    do_read("R6", b, wb);
    check("R6", W'(b[W-1:ID_W] - a[W-1:ID_W]), W'(1));

    // R5: code 11 behaves as nominal
    slew = 2'b11;
    do_read("R5", a, wa);
    do_read("R5", b, wb);
    check("R5", W'(b[W-1:ID_W] - a[W-1:ID_W]), W'(BASE_INC));

    // R4: idle with fast slew, no request -> no valid (monitor), then read
    slew = 2'b01;
    repeat (3 * TICK_DIV + 1) @(negedge clk);
    do_read("R4", a, wa);
    check("R7", W'(wa), W'(0));
    check("R4", W'(a[W-1:ID_W] > b[W-1:ID_W]), W'(1));

    // R3: string of back-to-back reads with changing slew
    b = a;
    for (int i = 0; i < 24; i++) begin
      slew = 2'(i % 4);
      do_read("R3", a, wa);
      check("R3", W'(a > b), W'(1));
      b = a;
      if (i % 5 == 0) repeat (i % 3) @(negedge clk);
    end

    repeat (2 * TICK_DIV) @(negedge clk);
    check("R8", W'(sb_q.size()), W'(0));
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule